// File: doc/BRIEF.md
# Mask-Selected Peripheral Bus Slave

This block is the peripheral-side end of a 16-bit, strobe-driven I/O bus. Accesses carry no address. The host first names a board by driving a one-hot, active-low mask on the data lines while it pulses a select strobe. Every board whose assigned line is low becomes the current target, and every other board drops out. A second mask strobe sets or clears each board's interrupt enable in the same way. During an interrupt-status read, each board answers on its own data line only. All strobes are active-low inputs that are synchronous to `clk`. A strobe acts on the first cycle it is seen low.

The board's own function is modelled as a register pair with a valid/ready stream on each side. The host write register is emptied through `wr_valid`/`wr_ready`. `wr_valid` stays high with `wr_data` stable until `wr_ready` is seen, and the slot takes no new word while it is full. If the host writes while the slot is full, the block holds the bus wait line low. The host must keep the strobe and the data in place until wait rises. The host read register is filled through `rd_valid`/`rd_ready`, and a word is taken on a cycle where both are high. A held word counts as the pending event. It raises the open-drain interrupt request when interrupts are enabled. A host data read clears it.

Tri-state pins are modelled as value and output-enable pairs. The board's assigned line is the parameter `SLOT`, taken modulo 8, so it always lies on D0..D7.

Top module: `kbs_slave`

## Requirements
- R1: After reset the board is not selected and interrupts are disabled. `irq_pull` is 0, `bus_oe` is all zero, `wait_oe` is 0, `wr_valid` is 0 and `rd_ready` is 1.
- R2: At the first low cycle of `sel_n`, the board becomes selected if `bus_in[SLOT]` is 0 and deselected if it is 1. The other data bits are ignored, and the new state shows one cycle later.
- R3: At the first low cycle of `irq_wr_n`, `bus_in[SLOT]` = 0 enables interrupts and 1 disables them. This takes effect one cycle later, whether or not the board is selected.
- R4: `irq_pull` (1 = pull the shared line low; the block never drives it high) is 1 exactly when a read word is pending and interrupts are enabled.
- R5: While `irq_rd_n` is low, `bus_oe` has only bit `SLOT` set. `bus_out[SLOT]` is 0 when `irq_pull` is 1 and 1 otherwise. This holds in the same cycle and takes priority over a data read.
- R6: While the board is selected and `dat_rd_n` is low, all 16 `bus_oe` bits are set and `bus_out` carries the held read word, in the same cycle.
- R7: A data read while selected clears the pending word one cycle after the first low cycle of `dat_rd_n`. `rd_ready` equals (no word pending) AND `dat_rd_n`, so the word cannot change during a read strobe.
- R8: While selected, one word per `dat_wr_n` strobe is captured from `bus_in` at the first cycle with the slot empty, and `wr_valid` rises one cycle later. A write strobe while not selected is ignored.
- R9: `wait_out` is 0 (hold) only while the board is selected, `dat_wr_n` is low, this strobe has not been taken yet, and the write slot is full. `wr_valid` with `wr_data` stays stable until `wr_ready`.
- R10: `wait_oe` equals the select state, so the wait line is high-impedance while the board is not selected.
- R11: With `irq_rd_n` high and no selected data read in progress, `bus_oe` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Select mask strobe, active low |
| irq_wr_n | input | 1 | Interrupt-enable mask strobe, active low |
| irq_rd_n | input | 1 | Interrupt-status read strobe, active low |
| dat_wr_n | input | 1 | Data write strobe, active low |
| dat_rd_n | input | 1 | Data read strobe, active low |
| bus_in | input | 16 | Value seen on the data lines |
| bus_out | output | 16 | Value driven onto the data lines |
| bus_oe | output | 16 | Per-bit drive enable for the data lines |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt line low |
| wait_out | output | 1 | Wait level, 0 = hold the access |
| wait_oe | output | 1 | Drive enable for the wait line |
| wr_valid | output | 1 | Host write word available to the function |
| wr_data | output | 16 | Host write word |
| wr_ready | input | 1 | Function accepts the write word |
| rd_valid | input | 1 | Function offers a word for the host |
| rd_data | input | 16 | Word offered for the host |
| rd_ready | output | 1 | Block accepts the offered word |

## Verification
Bus drives (`bus_oe`, `bus_out`, `wait_out`) and `rd_ready` follow their inputs in the same cycle. Every register result (select, enable, pending, `wr_valid`, `irq_pull`) is due one cycle after the strobe's first low cycle or after the stream handshake. The bench drives inputs just after a rising edge and compares every output at the following falling edge. It compares them against a behavioural model that updates at the rising edge, so same-cycle results and one-cycle results are each checked in exactly the cycle they are due.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int unsigned SEL_LINES = 8;

  typedef enum logic [1:0] {
    EDGE_SEL  = 2'd0,
    EDGE_IEN  = 2'd1,
    EDGE_DRD  = 2'd2
  } edge_idx_e;

  localparam int unsigned EDGE_N = 3;

  typedef enum logic [1:0] {
    DRV_NONE   = 2'd0,
    DRV_STATUS = 2'd1,
    DRV_DATA   = 2'd2
  } drive_e;
endpackage

// File: rtl/kbs_strobe_edge.sv
module kbs_strobe_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_n;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n[i] <= 1'b1;
      else        prev_n[i] <= strobe_n[i];
    end
    assign fall[i] = prev_n[i] & ~strobe_n[i];
  end
endmodule

// File: rtl/kbs_ctrl.sv
module kbs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_fall,
  input  logic ien_fall,
  input  logic slot_bit,
  output logic selected,
  output logic irq_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (sel_fall) selected <= ~slot_bit;
      if (ien_fall) irq_en   <= ~slot_bit;
    end
  end
endmodule

// File: rtl/kbs_wr_port.sv
module kbs_wr_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              dat_wr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic              hold,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready
);
  logic full_q;
  logic taken_q;
  logic [DATA_W-1:0] word_q;
  logic want;
  logic capture;

  assign want    = selected & ~dat_wr_n & ~taken_q;
  assign capture = want & ~full_q;
  assign hold    = want & full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      taken_q <= 1'b0;
      word_q  <= '0;
    end else begin
      if (capture) begin
        full_q <= 1'b1;
        word_q <= bus_in;
      end else if (full_q && wr_ready) begin
        full_q <= 1'b0;
      end
      if (dat_wr_n)     taken_q <= 1'b0;
      else if (capture) taken_q <= 1'b1;
    end
  end

  assign wr_valid = full_q;
  assign wr_data  = word_q;
endmodule

// File: rtl/kbs_rd_port.sv
module kbs_rd_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              dat_rd_n,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              pending,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] word_q;
  logic pend_q;

  assign rd_ready = ~pend_q & dat_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else if (pop) begin
      pend_q <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      pend_q <= 1'b1;
      word_q <= rd_data;
    end
  end

  assign pending = pend_q;
  assign word    = word_q;
endmodule

// File: rtl/kbs_slave.sv
module kbs_slave #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              irq_wr_n,
  input  logic              irq_rd_n,
  input  logic              dat_wr_n,
  input  logic              dat_rd_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] bus_oe,
  output logic              irq_pull,
  output logic              wait_out,
  output logic              wait_oe,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_ready
);
  import kbs_pkg::*;

  localparam int unsigned LINE = SLOT % SEL_LINES;
  localparam logic [DATA_W-1:0] LINE_MASK = DATA_W'(1) << LINE;

  logic [EDGE_N-1:0] strobes_n;
  logic [EDGE_N-1:0] falls;
  logic selected, irq_en;
  logic hold;
  logic pending;
  logic [DATA_W-1:0] rd_word;
  logic req;
  drive_e drv;

  assign strobes_n[EDGE_SEL] = sel_n;
  assign strobes_n[EDGE_IEN] = irq_wr_n;
  assign strobes_n[EDGE_DRD] = dat_rd_n;

  kbs_strobe_edge #(.N(EDGE_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobes_n), .fall(falls)
  );

  kbs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sel_fall(falls[EDGE_SEL]), .ien_fall(falls[EDGE_IEN]),
    .slot_bit(bus_in[LINE]),
    .selected(selected), .irq_en(irq_en)
  );

  kbs_wr_port #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .selected(selected), .dat_wr_n(dat_wr_n),
    .bus_in(bus_in), .hold(hold),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  kbs_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .pop(selected & falls[EDGE_DRD]), .dat_rd_n(dat_rd_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .pending(pending), .word(rd_word)
  );

  assign req      = pending & irq_en;
  assign irq_pull = req;
  assign wait_oe  = selected;
  assign wait_out = ~hold;

  always_comb begin
    if (!irq_rd_n)                 drv = DRV_STATUS;
    else if (selected && !dat_rd_n) drv = DRV_DATA;
    else                           drv = DRV_NONE;
  end

  always_comb begin
    bus_out = '1;
    bus_oe  = '0;
    unique case (drv)
      DRV_STATUS: begin
        bus_oe        = LINE_MASK;
        bus_out[LINE] = ~req;
      end
      DRV_DATA: begin
        bus_oe  = '1;
        bus_out = rd_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/kbs_slave_chk.sv
module kbs_slave_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              irq_rd_n,
  input logic              dat_rd_n,
  input logic              dat_wr_n,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] bus_oe,
  input logic              irq_pull,
  input logic              wait_out,
  input logic              wait_oe,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              rd_ready
);
  localparam int unsigned LINE = SLOT % 8;

  p_sel_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n) && !sel_n) |=> (wait_oe == !$past(bus_in[LINE])));

  p_irq_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull && dat_rd_n) |-> !rd_ready);

  p_status_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_rd_n |-> ($onehot0(bus_oe) && bus_oe[LINE] && bus_out[LINE] == !irq_pull));

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dat_rd_n) && !dat_rd_n && wait_oe) |=> !irq_pull);

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  p_wait_only_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_oe || dat_wr_n) |-> wait_out);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd_n && (dat_rd_n || !wait_oe)) |-> (bus_oe == '0));
endmodule

bind kbs_slave kbs_slave_chk #(.DATA_W(DATA_W), .SLOT(SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .irq_rd_n(irq_rd_n),
  .dat_rd_n(dat_rd_n), .dat_wr_n(dat_wr_n), .bus_in(bus_in),
  .bus_out(bus_out), .bus_oe(bus_oe), .irq_pull(irq_pull),
  .wait_out(wait_out), .wait_oe(wait_oe), .wr_valid(wr_valid),
  .wr_data(wr_data), .wr_ready(wr_ready), .rd_ready(rd_ready)
);

// File: tb/kbs_slave_test.sv
module kbs_slave_test;
  localparam int DW = 16;
  localparam int SLOT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1, irq_wr_n = 1, irq_rd_n = 1, dat_wr_n = 1, dat_rd_n = 1;
  logic [DW-1:0] bus_in = '1;
  logic [DW-1:0] bus_out, bus_oe, wr_data;
  logic irq_pull, wait_out, wait_oe, wr_valid, rd_ready;
  logic wr_ready = 0, rd_valid = 0;
  logic [DW-1:0] rd_data = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbs_slave #(.DATA_W(DW), .SLOT(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .irq_wr_n(irq_wr_n),
    .irq_rd_n(irq_rd_n), .dat_wr_n(dat_wr_n), .dat_rd_n(dat_rd_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .irq_pull(irq_pull), .wait_out(wait_out), .wait_oe(wait_oe),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready)
  );

  // behavioural reference state
  bit m_sel, m_ien, m_pend, m_wfull, m_wtaken;
  bit m_psel = 1, m_pien = 1, m_prd = 1;
  logic [DW-1:0] m_rdata, m_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel <= 0; m_ien <= 0; m_pend <= 0; m_wfull <= 0; m_wtaken <= 0;
      m_psel <= 1; m_pien <= 1; m_prd <= 1; m_rdata <= '0; m_wdata <= '0;
    end else begin
      if (m_psel && !sel_n) m_sel <= !bus_in[SLOT];
      if (m_pien && !irq_wr_n) m_ien <= !bus_in[SLOT];
      if (m_sel && m_prd && !dat_rd_n) m_pend <= 0;
      else if (rd_valid && !m_pend && dat_rd_n) begin
        m_pend <= 1; m_rdata <= rd_data;
      end
      if (m_sel && !dat_wr_n && !m_wtaken && !m_wfull) begin
        m_wfull <= 1; m_wdata <= bus_in; m_wtaken <= 1;
      end else if (m_wfull && wr_ready) m_wfull <= 0;
      if (dat_wr_n) m_wtaken <= 0;
      m_psel <= sel_n; m_pien <= irq_wr_n; m_prd <= dat_rd_n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [DW-1:0] e_oe, e_out;
      bit e_req;
      e_req = m_pend && m_ien;
      e_oe = '0; e_out = '0;
      if (!irq_rd_n) begin
        e_oe = DW'(1) << SLOT; e_out[SLOT] = !e_req;
      end else if (m_sel && !dat_rd_n) begin
        e_oe = '1; e_out = m_rdata;
      end
      check(bus_oe == e_oe, "R5/R6/R11 bus_oe", bus_oe, e_oe);
      check((bus_out & e_oe) == (e_out & e_oe), "R5/R6 bus_out", bus_out & e_oe, e_out & e_oe);
      check(irq_pull == e_req, "R4 irq_pull", DW'(irq_pull), DW'(e_req));
      check(wait_oe == m_sel, "R10 wait_oe", DW'(wait_oe), DW'(m_sel));
      check(wait_out == !(m_sel && !dat_wr_n && !m_wtaken && m_wfull),
            "R9 wait_out", DW'(wait_out), DW'(!(m_sel && !dat_wr_n && !m_wtaken && m_wfull)));
      check(wr_valid == m_wfull, "R8 wr_valid", DW'(wr_valid), DW'(m_wfull));
      if (m_wfull) check(wr_data == m_wdata, "R8 wr_data", wr_data, m_wdata);
      check(rd_ready == (!m_pend && dat_rd_n), "R7 rd_ready", DW'(rd_ready),
            DW'(!m_pend && dat_rd_n));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    rst_n = 1;
    at_neg();
    // R1 reset state
    check(!wait_oe && !irq_pull && bus_oe == 0 && !wr_valid && rd_ready,
          "R1 reset state", {wait_oe, irq_pull, wr_valid, rd_ready}, 16'h1);
    step(1);

    // R2 line high: not selected; other lines low are ignored
    bus_in = ~(DW'(1) << 5) & ~(DW'(1) << 0); sel_n = 0; step(1); sel_n = 1; bus_in = '1;
    at_neg(); check(!wait_oe, "R2 not selected", DW'(wait_oe), 0);
    step(1);
    // R8 write while not selected ignored
    bus_in = 16'h0F0F; dat_wr_n = 0; step(2); dat_wr_n = 1; bus_in = '1;
    at_neg(); check(!wr_valid, "R8 unselected write ignored", DW'(wr_valid), 0);
    step(1);

    // R2 line low: selected
    bus_in = ~(DW'(1) << SLOT); sel_n = 0; step(1); sel_n = 1; bus_in = '1;
    at_neg(); check(wait_oe, "R2 selected", DW'(wait_oe), 1);
    step(1);

    // R8 write, then R9 back-pressure on a second write
    bus_in = 16'hA5C3; dat_wr_n = 0; step(3); dat_wr_n = 1;
    at_neg(); check(wr_valid && wr_data == 16'hA5C3, "R8 captured word", wr_data, 16'hA5C3);
    step(1);
    bus_in = 16'h3C5A; dat_wr_n = 0; step(0);
    at_neg(); check(!wait_out, "R9 wait held low while full", DW'(wait_out), 0);
    step(2);
    wr_ready = 1; step(1); wr_ready = 0;
    at_neg(); check(wait_out, "R9 wait released after pop", DW'(wait_out), 1);
    step(1); dat_wr_n = 1; bus_in = '1;
    at_neg(); check(wr_data == 16'h3C5A, "R8 second word", wr_data, 16'h3C5A);
    wr_ready = 1; step(1); wr_ready = 0;

    // R4 pending but disabled
    rd_data = 16'h1234; rd_valid = 1; step(1); rd_valid = 0; rd_data = 0;
    at_neg(); check(!irq_pull && !rd_ready, "R4 pending, disabled", DW'(irq_pull), 0);
    step(1);
    // R3 enable, R4 request
    bus_in = ~(DW'(1) << SLOT); irq_wr_n = 0; step(1); irq_wr_n = 1; bus_in = '1;
    at_neg(); check(irq_pull, "R3 enable gives R4 request", DW'(irq_pull), 1);
    step(1);
    // R5 status read
    irq_rd_n = 0; step(0);
    at_neg(); check(bus_oe == (DW'(1) << SLOT) && !bus_out[SLOT], "R5 status", bus_oe, DW'(1) << SLOT);
    step(1); irq_rd_n = 1;
    // R6 data read and R7 clear
    dat_rd_n = 0; step(0);
    at_neg(); check(bus_oe == '1 && bus_out == 16'h1234, "R6 read word", bus_out, 16'h1234);
    rd_valid = 1; rd_data = 16'h7777;
    step(1);
    at_neg(); check(!irq_pull && !rd_ready && bus_out == 16'h1234, "R7 cleared, held", bus_out, 16'h1234);
    step(1); dat_rd_n = 1;
    step(1); rd_valid = 0;
    at_neg(); check(irq_pull, "R7 refilled after strobe", DW'(irq_pull), 1);
    // R3 disable with line high
    step(1); bus_in = '1; irq_wr_n = 0; step(1); irq_wr_n = 1;
    at_neg(); check(!irq_pull, "R3 disable", DW'(irq_pull), 0);
    step(1);
    irq_rd_n = 0; step(0);
    at_neg(); check(bus_out[SLOT], "R5 status idle high", DW'(bus_out[SLOT]), 1);
    step(1); irq_rd_n = 1;

    // deselect, then R11 read not driven and R10 wait released
    bus_in = '1; sel_n = 0; step(1); sel_n = 1;
    dat_rd_n = 0; step(0);
    at_neg(); check(bus_oe == 0 && !wait_oe, "R11 unselected read quiet", bus_oe, 0);
    step(2); dat_rd_n = 1;
    at_neg(); check(!rd_ready && !irq_pull, "R7 no pop when unselected", DW'(rd_ready), 0);
    step(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule